// File: doc/BRIEF.md
# RTC Interrupt Status and Clear Logic

This block sits between the event outputs of a real-time clock core and the CPU. It catches one-cycle strobes for the daily alarm, the stopwatch expiry and the periodic day, minute and second ticks. It holds each event as a sticky flag in one of two 32-bit status registers on a simple register bus. Software reads the flags and clears each one by writing 1 to its bit. The block drives two interrupt lines: one for alarm and stopwatch events, and one for periodic ticks.

The alarm has two status flags. One of them drives the interrupt. The other only records the event, so clearing it leaves the interrupt alone. A write to one of the module's read-only word locations changes no register. It only raises a bus-error flag. Bit positions below follow the register convention in which bit 0 is the most significant bit, so bit n of the register is `bus_rdata[31-n]`. The word address selects the register: 0 is the alarm/stopwatch register, 1 is the periodic register, and 2 and 3 are read-only locations.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset every flag is 0 and both interrupt outputs are 0. A read of word 0 then returns only the minutes value, and a read of word 1 returns 0.
- R2: An `evt_alarm` strobe sets both the alarm interrupt flag (bit 7 of word 0, `bus_rdata[24]`) and the alarm status flag (bit 23, `bus_rdata[8]`). An `evt_stopwatch` strobe sets the stopwatch flag (bit 15, `bus_rdata[16]`).
- R3: Writing 1 to a flag's bit clears that flag on the next clock. Writing 0 leaves it unchanged.
- R4: `irq_alarm_sw` is high while the alarm interrupt flag or the stopwatch flag is set. It drops only once both are clear.
- R5: Clearing the alarm status flag leaves the alarm interrupt flag and `irq_alarm_sw` unchanged. Clearing the alarm interrupt flag leaves the status flag set.
- R6: Bits 24 to 31 of word 0 (`bus_rdata[7:0]`) show `sw_minutes` directly, with no register delay.
- R7: `evt_day`, `evt_minute` and `evt_second` set the day flag (bit 15, `bus_rdata[16]`), the minute flag (bit 23, `bus_rdata[8]`) and the second flag (bit 31, `bus_rdata[0]`) of word 1. Each of these flags clears by write-1.
- R8: `irq_periodic` is the OR of the day, minute and second flags. The bus-error flag has no effect on it.
- R9: A write to word 2 or 3 sets the bus-error flag (bit 7 of word 1, `bus_rdata[24]`) and changes no other flag. Reads of words 2 and 3 return 0. The bus-error flag clears by write-1.
- R10: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R11: All bits other than the flag and minutes positions read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_alarm | input | 1 | Daily alarm match strobe |
| evt_stopwatch | input | 1 | Stopwatch expiry strobe |
| evt_day | input | 1 | Midnight strobe |
| evt_minute | input | 1 | Minute tick strobe |
| evt_second | input | 1 | Second tick strobe |
| sw_minutes | input | 8 | Stopwatch minutes remaining |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq_alarm_sw | output | 1 | Alarm/stopwatch interrupt |
| irq_periodic | output | 1 | Periodic tick interrupt |

## Verification
The alarm and stopwatch strobes are raised both one at a time and together. The interrupt is then cleared one source at a time, which shows whether the output really waits for both sources. Writes use single-bit, all-zero and all-ones patterns, and one pattern clears only the second alarm flag. These show that each clear reaches only its own flag. A strobe and a clear are aimed at the same flag in the same cycle, writes are sent to the read-only words while other flags are set, and the bus-error flag is set while all periodic flags are clear. These cases separate set priority, write isolation and the makeup of the periodic OR.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_W = 32;
  localparam int MIN_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [2:0] {
    FL_ALM_INT  = 3'd0,
    FL_SW_INT   = 3'd1,
    FL_ALM_STAT = 3'd2,
    FL_DAY      = 3'd3,
    FL_MIN      = 3'd4,
    FL_SEC      = 3'd5,
    FL_BUSERR   = 3'd6
  } flag_e;
  localparam int NFLAG = 7;

  // register bit n (bit 0 = msb) sits at vector index REG_W-1-n
  localparam int POS_B7  = REG_W - 1 - 7;
  localparam int POS_B15 = REG_W - 1 - 15;
  localparam int POS_B23 = REG_W - 1 - 23;
  localparam int POS_B31 = REG_W - 1 - 31;

  localparam logic [ADDR_W-1:0] ADDR_ALM_SW   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIODIC = 2'd1;

  localparam logic [REG_W-1:0] RESERVED_MASK = 32'hFEFE_FE00;
endpackage

// File: rtl/rtc_irq_rst_sync.sv
module rtc_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic en;
    logic nxt;

    always_comb begin
      en  = set_i[i] | clr_i[i];
      nxt = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[i] <= 1'b0;
      else if (en) flag_q[i] <= nxt;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/rtc_irq_regif.sv
module rtc_irq_regif
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [NFLAG-1:0]  flag_q,
  input  logic [MIN_W-1:0]  sw_minutes,
  output logic [NFLAG-1:0]  clr_o,
  output logic              ro_wr_o,
  output logic [REG_W-1:0]  bus_rdata
);
  logic wr_en;
  logic hit_as;
  logic hit_per;
  logic unused_wdata;

  always_comb begin
    wr_en   = bus_sel & bus_wr;
    hit_as  = (bus_addr == ADDR_ALM_SW);
    hit_per = (bus_addr == ADDR_PERIODIC);
    ro_wr_o = wr_en & ~hit_as & ~hit_per;

    clr_o              = '0;
    clr_o[FL_ALM_INT]  = wr_en & hit_as  & bus_wdata[POS_B7];
    clr_o[FL_SW_INT]   = wr_en & hit_as  & bus_wdata[POS_B15];
    clr_o[FL_ALM_STAT] = wr_en & hit_as  & bus_wdata[POS_B23];
    clr_o[FL_BUSERR]   = wr_en & hit_per & bus_wdata[POS_B7];
    clr_o[FL_DAY]      = wr_en & hit_per & bus_wdata[POS_B15];
    clr_o[FL_MIN]      = wr_en & hit_per & bus_wdata[POS_B23];
    clr_o[FL_SEC]      = wr_en & hit_per & bus_wdata[POS_B31];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_as) begin
      bus_rdata[POS_B7]      = flag_q[FL_ALM_INT];
      bus_rdata[POS_B15]     = flag_q[FL_SW_INT];
      bus_rdata[POS_B23]     = flag_q[FL_ALM_STAT];
      bus_rdata[MIN_W-1:0]   = sw_minutes;
    end else if (hit_per) begin
      bus_rdata[POS_B7]      = flag_q[FL_BUSERR];
      bus_rdata[POS_B15]     = flag_q[FL_DAY];
      bus_rdata[POS_B23]     = flag_q[FL_MIN];
      bus_rdata[POS_B31]     = flag_q[FL_SEC];
    end
  end

  assign unused_wdata = ^bus_wdata;

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & RESERVED_MASK) == '0);
  assert_ro_write_clears_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr_o |-> (clr_o == '0));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_alarm,
  input  logic              evt_stopwatch,
  input  logic              evt_day,
  input  logic              evt_minute,
  input  logic              evt_second,
  input  logic [MIN_W-1:0]  sw_minutes,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_alarm_sw,
  output logic              irq_periodic
);
  logic             rst_i_n;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic             ro_wr;

  rtc_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rtc_irq_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flag_q     (flag_q),
    .sw_minutes (sw_minutes),
    .clr_o      (clr_v),
    .ro_wr_o    (ro_wr),
    .bus_rdata  (bus_rdata)
  );

  always_comb begin
    set_v              = '0;
    set_v[FL_ALM_INT]  = evt_alarm;
    set_v[FL_ALM_STAT] = evt_alarm;
    set_v[FL_SW_INT]   = evt_stopwatch;
    set_v[FL_DAY]      = evt_day;
    set_v[FL_MIN]      = evt_minute;
    set_v[FL_SEC]      = evt_second;
    set_v[FL_BUSERR]   = ro_wr;
  end

  rtc_irq_flag_bank #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_q (flag_q)
  );

  always_comb begin
    irq_alarm_sw = flag_q[FL_ALM_INT] | flag_q[FL_SW_INT];
    irq_periodic = flag_q[FL_DAY] | flag_q[FL_MIN] | flag_q[FL_SEC];
  end

  assert_irq_waits_both_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_alarm_sw && flag_q[FL_SW_INT] && !clr_v[FL_SW_INT]) |=> irq_alarm_sw);
  assert_stat_clear_keeps_irq_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flag_q[FL_ALM_INT] && clr_v[FL_ALM_STAT] && !clr_v[FL_ALM_INT]) |=> flag_q[FL_ALM_INT]);
  assert_ro_write_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && bus_wr && bus_addr[1]) |=> flag_q[FL_BUSERR]);
  assert_alarm_sets_both_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    evt_alarm |=> (flag_q[FL_ALM_INT] && flag_q[FL_ALM_STAT] && irq_alarm_sw));
  assert_buserr_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flag_q[FL_BUSERR] && !flag_q[FL_DAY] && !flag_q[FL_MIN] && !flag_q[FL_SEC]) |-> !irq_periodic);
endmodule

// File: tb/rtc_irq_status_test.sv
module rtc_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_alarm = 1'b0, evt_stopwatch = 1'b0;
  logic        evt_day = 1'b0, evt_minute = 1'b0, evt_second = 1'b0;
  logic [7:0]  sw_minutes = 8'h5A;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_alarm_sw, irq_periodic;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_ai, m_sw, m_as, m_day, m_min, m_sec, m_be;

  always #4 clk = ~clk;

  rtc_irq_status uut (
    .clk(clk), .rst_n(rst_n),
    .evt_alarm(evt_alarm), .evt_stopwatch(evt_stopwatch),
    .evt_day(evt_day), .evt_minute(evt_minute), .evt_second(evt_second),
    .sw_minutes(sw_minutes),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_alarm_sw(irq_alarm_sw), .irq_periodic(irq_periodic)
  );

  function automatic bit upd(bit cur, bit set, bit clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_ai, m_sw, m_as, m_day, m_min, m_sec, m_be} = '0;
    end else begin
      bit w0, w1, wro;
      w0  = bus_sel && bus_wr && bus_addr == 2'd0;
      w1  = bus_sel && bus_wr && bus_addr == 2'd1;
      wro = bus_sel && bus_wr && bus_addr >= 2'd2;
      m_ai  = upd(m_ai,  evt_alarm,     w0 && bus_wdata[24]);
      m_sw  = upd(m_sw,  evt_stopwatch, w0 && bus_wdata[16]);
      m_as  = upd(m_as,  evt_alarm,     w0 && bus_wdata[8]);
      m_be  = upd(m_be,  wro,           w1 && bus_wdata[24]);
      m_day = upd(m_day, evt_day,       w1 && bus_wdata[16]);
      m_min = upd(m_min, evt_minute,    w1 && bus_wdata[8]);
      m_sec = upd(m_sec, evt_second,    w1 && bus_wdata[0]);
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = '0;
    if (bus_addr == 2'd0) begin
      exp_rd[24] = m_ai; exp_rd[16] = m_sw; exp_rd[8] = m_as; exp_rd[7:0] = sw_minutes;
    end else if (bus_addr == 2'd1) begin
      exp_rd[24] = m_be; exp_rd[16] = m_day; exp_rd[8] = m_min; exp_rd[0] = m_sec;
    end
    check(cur_req, "irq_alarm_sw", {31'd0, irq_alarm_sw}, {31'd0, m_ai | m_sw});
    check(cur_req, "irq_periodic", {31'd0, irq_periodic}, {31'd0, m_day | m_min | m_sec});
    check(cur_req, "bus_rdata", bus_rdata, exp_rd);
  endtask

  // one cycle: compare current outputs, then drive the next inputs
  task automatic cyc(bit a, bit s, bit d, bit mi, bit se,
                     bit sel, bit wr, logic [1:0] addr, logic [31:0] wd);
    @(negedge clk);
    compare();
    evt_alarm = a; evt_stopwatch = s; evt_day = d; evt_minute = mi; evt_second = se;
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
  endtask

  task automatic rd(logic [1:0] addr);
    cyc(0, 0, 0, 0, 0, 1, 0, addr, '0);
  endtask

  task automatic wr(logic [1:0] addr, logic [31:0] wd);
    cyc(0, 0, 0, 0, 0, 1, 1, addr, wd);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) rd(2'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd1); rd(2'd1); rd(2'd0); rd(2'd0);
    check("R1", "reset word0", bus_rdata, 32'h0000_005A);

    // R2: alarm sets both alarm flags, stopwatch sets its flag
    cur_req = "R2";
    cyc(1, 0, 0, 0, 0, 1, 0, 2'd0, '0);
    rd(2'd0); rd(2'd0);
    check("R2", "alarm flags", bus_rdata, 32'h0100_015A);
    cyc(0, 1, 0, 0, 0, 1, 0, 2'd0, '0);
    rd(2'd0);

    // R3: writing zeros changes nothing; R5: clear status only
    cur_req = "R3";
    wr(2'd0, 32'h0000_0000); rd(2'd0);
    cur_req = "R5";
    wr(2'd0, 32'h0000_0100); rd(2'd0); rd(2'd0);
    check("R5", "alarm int kept", bus_rdata, 32'h0101_005A);

    // R4: clear alarm int, irq stays for stopwatch; then clear stopwatch
    cur_req = "R4";
    wr(2'd0, 32'h0100_0000); rd(2'd0); rd(2'd0);
    check("R4", "irq held by stopwatch", {31'd0, irq_alarm_sw}, 32'd1);
    wr(2'd0, 32'h0001_0000); rd(2'd0); rd(2'd0);
    check("R4", "irq dropped", {31'd0, irq_alarm_sw}, 32'd0);

    // R5: clearing alarm int keeps status copy
    cur_req = "R5";
    cyc(1, 0, 0, 0, 0, 1, 0, 2'd0, '0);
    wr(2'd0, 32'h0100_0000); rd(2'd0); rd(2'd0);
    check("R5", "status kept", bus_rdata, 32'h0000_015A);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0);

    // R6: minutes field follows input immediately
    cur_req = "R6";
    @(negedge clk); sw_minutes = 8'hC3;
    #1 check("R6", "minutes", {24'd0, bus_rdata[7:0]}, 32'h0000_00C3);
    rd(2'd0); sw_minutes = 8'h07; rd(2'd0);

    // R7: periodic ticks and their clears
    cur_req = "R7";
    cyc(0, 0, 1, 0, 0, 1, 0, 2'd1, '0);
    cyc(0, 0, 0, 1, 0, 1, 0, 2'd1, '0);
    cyc(0, 0, 0, 0, 1, 1, 0, 2'd1, '0);
    rd(2'd1); rd(2'd1);
    check("R7", "all ticks", bus_rdata, 32'h0001_0101);
    wr(2'd1, 32'h0000_0100); rd(2'd1);
    wr(2'd1, 32'h0001_0001); rd(2'd1); rd(2'd1);
    check("R7", "ticks cleared", bus_rdata, 32'h0000_0000);

    // R9: writes to read-only words raise bus error only
    cur_req = "R9";
    cyc(0, 1, 0, 1, 0, 1, 0, 2'd1, '0);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2); rd(2'd3);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd1); rd(2'd0);

    // R8: bus error alone leaves periodic irq low
    cur_req = "R8";
    wr(2'd1, 32'h0000_0100); rd(2'd1); rd(2'd1);
    check("R8", "buserr no irq", {31'd0, irq_periodic}, 32'd0);
    cur_req = "R9";
    wr(2'd1, 32'h0100_0000); rd(2'd1);
    wr(2'd0, 32'h0001_0000); rd(2'd0);

    // R10: set and clear in the same cycle -> set wins
    cur_req = "R10";
    cyc(1, 0, 0, 0, 0, 1, 1, 2'd0, 32'h0100_0100);
    rd(2'd0); rd(2'd0);
    check("R10", "set wins", bus_rdata, 32'h0100_0107);
    cyc(0, 0, 0, 0, 1, 1, 1, 2'd1, 32'h0000_0001);
    rd(2'd1); rd(2'd1);

    // R11: reserved bits zero throughout (full-word compare every cycle)
    cur_req = "R11";
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0); rd(2'd1); rd(2'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule